// File: doc/BRIEF.md
# Directory Successor Proxy Table

This block sits beside a directory that has taken over, as a proxy, the uncommitted line data of speculating processors. When one processor reads a line whose speculative data the directory holds, the block notes that the reader now depends on the line's last writer. It keeps one successor bit vector per processor; bit j of processor i's vector means processor j depends on processor i. When a processor later commits or aborts, the directory relays that notice to every processor marked in its vector. The relay is a single forwarded notice carrying a destination bitmask, and the block then forgets every dependency the finished processor took part in.

Stores to a proxied shared line do not create records here. The processors that share the line record write-after-read order themselves, so the block only returns the sharer set, minus the requester, as an invalidation mask. A separate input reports that the directory's version storage has overflowed for a processor. The block answers it with a one-hot abort demand for that processor.

Requests come on two channels: a notice channel, which is always accepted, and a record channel with a ready signal. The block handles one request per cycle, and notices win over records. A controller with five named states decides what the registered outputs show in the following cycle:
- IDLE: nothing was taken.
- FWD_COMMIT: a commit notice was taken.
- FWD_ABORT: an abort notice was taken.
- RECORD: a read dependency was taken.
- INVAL: a store query was taken.

Each cycle the next state is chosen from the inputs, in that priority order: notice, then record, then IDLE.

Top module: `sproxy_dir`

## Requirements
- R1: After reset all successor vectors are empty, `fwd_valid`, `inv_valid` and `kill_valid` are 0, and `rec_ready` is 1 while `note_valid` is 0.
- R2: An accepted read record (`rec_is_store`=0) with reader `rec_src` and last writer `rec_writer` sets bit `rec_src` in the vector of `rec_writer`.
- R3: A read record whose reader equals its writer changes no vector.
- R4: A commit notice (`note_abort`=0) from P gives, in the next cycle, a one-cycle pulse with `fwd_valid`=1, `fwd_abort`=0 and `fwd_mask` equal to P's vector as it stood when the notice was taken (bit i = processor i).
- R5: An abort notice (`note_abort`=1) from P behaves as in R4, but with `fwd_abort`=1.
- R6: Taking a notice from P empties P's vector and clears bit P in every other vector.
- R7: An accepted store query (`rec_is_store`=1) gives, in the next cycle, `inv_valid`=1 with `inv_mask` = `rec_sharers` with bit `rec_src` cleared. It changes no vector.
- R8: While `note_valid`=1, `rec_ready` is 0. The one exception is a read record whose `rec_writer` equals `note_src`: that record is consumed (`rec_ready`=1) and discarded without being recorded.
- R9: `ovf_valid` with processor `ovf_proc` gives, in the next cycle, `kill_valid`=1 with `kill_mask` one-hot at bit `ovf_proc`.
- R10: A record offered while `rec_ready`=0 has no effect on any vector or output.
- R11: `fwd_valid`, `inv_valid` and `kill_valid` are single-cycle pulses that are 0 in a cycle following no matching request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| note_valid | input | 1 | Commit or abort notice present |
| note_abort | input | 1 | 1 = abort notice, 0 = commit notice |
| note_src | input | IW | Processor that finished |
| rec_valid | input | 1 | Record-channel request present |
| rec_ready | output | 1 | Record-channel request consumed this cycle |
| rec_is_store | input | 1 | 1 = store query, 0 = read dependency record |
| rec_src | input | IW | Reader (read record) or requester (store query) |
| rec_writer | input | IW | Last writer of the line (read record) |
| rec_sharers | input | N | Current sharers of the line (store query) |
| ovf_valid | input | 1 | Version storage overflow report |
| ovf_proc | input | IW | Processor whose transaction must abort |
| fwd_valid | output | 1 | Forwarded notice valid |
| fwd_abort | output | 1 | Forwarded notice is an abort |
| fwd_mask | output | N | Destinations of the forwarded notice |
| inv_valid | output | 1 | Invalidation set valid |
| inv_mask | output | N | Sharers to invalidate |
| kill_valid | output | 1 | Overflow abort demand valid |
| kill_mask | output | N | One-hot processor that must abort |

## Verification
Every registered result of this block is due exactly one clock edge after the request that caused it. A notice or query driven just after a falling edge is captured at the next rising edge, and the forwarded mask, invalidation set or abort demand is read at the falling edge after that. `rec_ready` is combinational, so the bench reads it shortly after driving, inside the same cycle. The bench never reads a vector directly; it observes vector contents only as the `fwd_mask` of a later notice, always placed in a cycle with no other request pending.

// File: rtl/sproxy_pkg.sv
package sproxy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_FWD_COMMIT = 3'd1,
        ST_FWD_ABORT  = 3'd2,
        ST_RECORD     = 3'd3,
        ST_INVAL      = 3'd4
    } sproxy_state_e;

endpackage

// File: rtl/sproxy_decode.sv
module sproxy_decode #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [IW-1:0] id,
    output logic [N-1:0]  onehot
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign onehot[g] = (id == IW'(g));
    end
endmodule

// File: rtl/sproxy_table.sv
module sproxy_table #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_owner,
    input  logic [N-1:0]  set_bits,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_id,
    input  logic [N-1:0]  clr_onehot,
    input  logic [IW-1:0] rd_id,
    output logic [N-1:0]  rd_row
);
    logic [N-1:0] rows [N];

    for (genvar r = 0; r < N; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rows[r] <= '0;
            end else if (clr_en) begin
                if (clr_id == IW'(r)) begin
                    rows[r] <= '0;
                end else begin
                    rows[r] <= rows[r] & ~clr_onehot;
                end
            end else if (set_en && (set_owner == IW'(r))) begin
                rows[r] <= rows[r] | set_bits;
            end
        end
    end

    always_comb begin
        rd_row = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_id == IW'(i)) begin
                rd_row = rows[i];
            end
        end
    end
endmodule

// File: rtl/sproxy_fsm.sv
module sproxy_fsm
    import sproxy_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take_note,
    input  logic         note_abort,
    input  logic         take_rec,
    input  logic         rec_is_store,
    input  logic [N-1:0] note_row,
    input  logic [N-1:0] inv_set,
    output logic         fwd_valid,
    output logic         fwd_abort,
    output logic [N-1:0] fwd_mask,
    output logic         inv_valid,
    output logic [N-1:0] inv_mask
);
    sproxy_state_e state, state_nx;
    logic [N-1:0]  pay_q, pay_nx;

    always_comb begin
        state_nx = ST_IDLE;
        pay_nx   = '0;
        if (take_note) begin
            state_nx = note_abort ? ST_FWD_ABORT : ST_FWD_COMMIT;
            pay_nx   = note_row;
        end else if (take_rec) begin
            state_nx = rec_is_store ? ST_INVAL : ST_RECORD;
            pay_nx   = rec_is_store ? inv_set : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pay_q <= '0;
        end else begin
            state <= state_nx;
            pay_q <= pay_nx;
        end
    end

    always_comb begin
        fwd_valid = 1'b0;
        fwd_abort = 1'b0;
        fwd_mask  = '0;
        inv_valid = 1'b0;
        inv_mask  = '0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_FWD_COMMIT: begin
                fwd_valid = 1'b1;
                fwd_mask  = pay_q;
            end
            ST_FWD_ABORT: begin
                fwd_valid = 1'b1;
                fwd_abort = 1'b1;
                fwd_mask  = pay_q;
            end
            ST_RECORD: begin
            end
            ST_INVAL: begin
                inv_valid = 1'b1;
                inv_mask  = pay_q;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/sproxy_dir.sv
module sproxy_dir #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          note_valid,
    input  logic          note_abort,
    input  logic [IW-1:0] note_src,
    input  logic          rec_valid,
    output logic          rec_ready,
    input  logic          rec_is_store,
    input  logic [IW-1:0] rec_src,
    input  logic [IW-1:0] rec_writer,
    input  logic [N-1:0]  rec_sharers,
    input  logic          ovf_valid,
    input  logic [IW-1:0] ovf_proc,
    output logic          fwd_valid,
    output logic          fwd_abort,
    output logic [N-1:0]  fwd_mask,
    output logic          inv_valid,
    output logic [N-1:0]  inv_mask,
    output logic          kill_valid,
    output logic [N-1:0]  kill_mask
);
    logic [N-1:0] note_oh, src_oh, ovf_oh, note_row;
    logic         drop_rec, take_rec, set_en;

    sproxy_decode #(.N(N), .IW(IW)) u_dec_note (.id(note_src), .onehot(note_oh));
    sproxy_decode #(.N(N), .IW(IW)) u_dec_src  (.id(rec_src),  .onehot(src_oh));
    sproxy_decode #(.N(N), .IW(IW)) u_dec_ovf  (.id(ovf_proc), .onehot(ovf_oh));

    // a read record naming a writer that finishes this very cycle is swallowed
    assign drop_rec  = note_valid && rec_valid && !rec_is_store && (rec_writer == note_src);
    assign rec_ready = !note_valid || drop_rec;
    assign take_rec  = rec_valid && !note_valid;
    assign set_en    = take_rec && !rec_is_store && (rec_src != rec_writer);

    sproxy_table #(.N(N), .IW(IW)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (set_en),
        .set_owner  (rec_writer),
        .set_bits   (src_oh),
        .clr_en     (note_valid),
        .clr_id     (note_src),
        .clr_onehot (note_oh),
        .rd_id      (note_src),
        .rd_row     (note_row)
    );

    sproxy_fsm #(.N(N)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_note    (note_valid),
        .note_abort   (note_abort),
        .take_rec     (take_rec),
        .rec_is_store (rec_is_store),
        .note_row     (note_row),
        .inv_set      (rec_sharers & ~src_oh),
        .fwd_valid    (fwd_valid),
        .fwd_abort    (fwd_abort),
        .fwd_mask     (fwd_mask),
        .inv_valid    (inv_valid),
        .inv_mask     (inv_mask)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kill_valid <= 1'b0;
            kill_mask  <= '0;
        end else begin
            kill_valid <= ovf_valid;
            kill_mask  <= ovf_valid ? ovf_oh : '0;
        end
    end
endmodule

// File: rtl/sproxy_dir_chk.sv
module sproxy_dir_chk #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          note_valid,
    input logic          note_abort,
    input logic [IW-1:0] note_src,
    input logic          rec_valid,
    input logic          rec_ready,
    input logic          rec_is_store,
    input logic [IW-1:0] rec_src,
    input logic [IW-1:0] rec_writer,
    input logic [N-1:0]  rec_sharers,
    input logic          ovf_valid,
    input logic [IW-1:0] ovf_proc,
    input logic          fwd_valid,
    input logic          fwd_abort,
    input logic [N-1:0]  fwd_mask,
    input logic          inv_valid,
    input logic [N-1:0]  inv_mask,
    input logic          kill_valid,
    input logic [N-1:0]  kill_mask
);
    logic [N-1:0] exp_inv;
    always_comb begin
        exp_inv = rec_sharers;
        exp_inv[rec_src] = 1'b0;
    end

    // R4 R5
    fwd_follows_note_chk: assert property (@(posedge clk) disable iff (!rst_n)
        note_valid |=> (fwd_valid && (fwd_abort == $past(note_abort))));

    // R7
    inv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_is_store && !note_valid) |=> (inv_valid && (inv_mask == $past(exp_inv))));

    // R8
    note_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (note_valid && !(rec_valid && !rec_is_store && (rec_writer == note_src))) |-> !rec_ready);

    // R9
    kill_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_valid |=> (kill_valid && ($countones(kill_mask) == 1) && kill_mask[$past(ovf_proc)]));

    // R11
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_valid, inv_valid}));

    // R11
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!note_valid && !rec_valid && !ovf_valid) |=> (!fwd_valid && !inv_valid && !kill_valid));
endmodule

bind sproxy_dir sproxy_dir_chk #(.N(N), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .note_valid(note_valid), .note_abort(note_abort),
    .note_src(note_src), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_is_store(rec_is_store), .rec_src(rec_src), .rec_writer(rec_writer),
    .rec_sharers(rec_sharers), .ovf_valid(ovf_valid), .ovf_proc(ovf_proc),
    .fwd_valid(fwd_valid), .fwd_abort(fwd_abort), .fwd_mask(fwd_mask),
    .inv_valid(inv_valid), .inv_mask(inv_mask), .kill_valid(kill_valid),
    .kill_mask(kill_mask)
);

// File: tb/sproxy_dir_tb.sv
module sproxy_dir_tb;
    localparam int N  = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          note_valid = 1'b0, note_abort = 1'b0;
    logic [IW-1:0] note_src = '0;
    logic          rec_valid = 1'b0, rec_is_store = 1'b0;
    logic          rec_ready;
    logic [IW-1:0] rec_src = '0, rec_writer = '0;
    logic [N-1:0]  rec_sharers = '0;
    logic          ovf_valid = 1'b0;
    logic [IW-1:0] ovf_proc = '0;
    logic          fwd_valid, fwd_abort, inv_valid, kill_valid;
    logic [N-1:0]  fwd_mask, inv_mask, kill_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sproxy_dir #(.N(N), .IW(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .note_valid(note_valid), .note_abort(note_abort),
        .note_src(note_src), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_is_store(rec_is_store), .rec_src(rec_src), .rec_writer(rec_writer),
        .rec_sharers(rec_sharers), .ovf_valid(ovf_valid), .ovf_proc(ovf_proc),
        .fwd_valid(fwd_valid), .fwd_abort(fwd_abort), .fwd_mask(fwd_mask),
        .inv_valid(inv_valid), .inv_mask(inv_mask), .kill_valid(kill_valid),
        .kill_mask(kill_mask)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        note_valid = 1'b0; rec_valid = 1'b0; ovf_valid = 1'b0;
    endtask

    // drive a read record for one cycle, then return to idle
    task automatic read_rec(input int rdr, input int wrt);
        @(negedge clk);
        rec_valid = 1'b1; rec_is_store = 1'b0;
        rec_src = IW'(rdr); rec_writer = IW'(wrt);
        @(negedge clk);
        idle_inputs();
    endtask

    // issue a notice and check the forwarded pulse due one edge later
    task automatic notice(input string req, input int p, input logic ab, input logic [N-1:0] exp);
        @(negedge clk);
        note_valid = 1'b1; note_abort = ab; note_src = IW'(p);
        @(negedge clk);
        idle_inputs();
        check(req, {31'd0, fwd_valid}, 32'd1);
        check(req, {31'd0, fwd_abort}, {31'd0, ab});
        check(req, {28'd0, fwd_mask}, {28'd0, exp});
        @(negedge clk);
        check({req, " pulse"}, {31'd0, fwd_valid}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 fwd_valid", {31'd0, fwd_valid}, 32'd0);
        check("R1 inv_valid", {31'd0, inv_valid}, 32'd0);
        check("R1 kill_valid", {31'd0, kill_valid}, 32'd0);
        check("R1 rec_ready", {31'd0, rec_ready}, 32'd1);
        for (int p = 0; p < N; p++) notice("R1 empty", p, 1'b0, 4'b0000);
    endtask

    task automatic t_read_commit();
        read_rec(1, 0);
        read_rec(2, 0);
        notice("R2 R4 commit", 0, 1'b0, 4'b0110);
        notice("R6 row cleared", 0, 1'b0, 4'b0000);
    endtask

    task automatic t_self();
        read_rec(3, 3);
        notice("R3 self", 3, 1'b0, 4'b0000);
    endtask

    task automatic t_abort_column();
        read_rec(2, 1);
        read_rec(2, 0);
        read_rec(3, 1);
        notice("R5 abort", 2, 1'b1, 4'b0000);
        notice("R5 R6 column", 1, 1'b1, 4'b1000);
        notice("R6 column", 0, 1'b0, 4'b0000);
    endtask

    task automatic t_store();
        read_rec(2, 0);
        @(negedge clk);
        rec_valid = 1'b1; rec_is_store = 1'b1; rec_src = 2'd0; rec_sharers = 4'b1011;
        @(negedge clk);
        idle_inputs();
        check("R7 inv_valid", {31'd0, inv_valid}, 32'd1);
        check("R7 inv_mask", {28'd0, inv_mask}, 32'h0000000a);
        check("R7 no fwd", {31'd0, fwd_valid}, 32'd0);
        @(negedge clk);
        check("R11 inv pulse", {31'd0, inv_valid}, 32'd0);
        notice("R7 table untouched", 0, 1'b0, 4'b0100);
    endtask

    task automatic t_priority();
        // stalled record held until accepted
        @(negedge clk);
        note_valid = 1'b1; note_abort = 1'b0; note_src = 2'd1;
        rec_valid = 1'b1; rec_is_store = 1'b0; rec_src = 2'd3; rec_writer = 2'd2;
        #2 check("R8 stall", {31'd0, rec_ready}, 32'd0);
        @(negedge clk);
        note_valid = 1'b0;
        check("R8 notice first", {31'd0, fwd_valid}, 32'd1);
        #2 check("R8 ready", {31'd0, rec_ready}, 32'd1);
        @(negedge clk);
        idle_inputs();
        notice("R8 late record", 2, 1'b0, 4'b1000);
        // record for the finishing writer is swallowed
        @(negedge clk);
        note_valid = 1'b1; note_abort = 1'b1; note_src = 2'd1;
        rec_valid = 1'b1; rec_is_store = 1'b0; rec_src = 2'd0; rec_writer = 2'd1;
        #2 check("R8 drop ready", {31'd0, rec_ready}, 32'd1);
        @(negedge clk);
        idle_inputs();
        notice("R8 dropped", 1, 1'b0, 4'b0000);
        // record withdrawn while stalled leaves nothing behind
        @(negedge clk);
        note_valid = 1'b1; note_abort = 1'b0; note_src = 2'd3;
        rec_valid = 1'b1; rec_is_store = 1'b0; rec_src = 2'd1; rec_writer = 2'd0;
        @(negedge clk);
        idle_inputs();
        notice("R10 withdrawn", 0, 1'b0, 4'b0000);
    endtask

    task automatic t_overflow();
        @(negedge clk);
        ovf_valid = 1'b1; ovf_proc = 2'd2;
        @(negedge clk);
        idle_inputs();
        check("R9 kill_valid", {31'd0, kill_valid}, 32'd1);
        check("R9 kill_mask", {28'd0, kill_mask}, 32'h4);
        @(negedge clk);
        check("R11 kill pulse", {31'd0, kill_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_commit();
        t_self();
        t_abort_column();
        t_store();
        t_priority();
        t_overflow();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule